// File: doc/BRIEF.md
# Age-Ordered Multi-Class Issue Selector

The block holds instructions whose operands are already available and decides which of them go to the functional units each cycle. Ready entries are kept in one small pool per operation class, and each pool feeds one kind of functional unit. Every entry carries a 16-bit sequence number and a thread ID. Each pool works out its own oldest entry (its head). A ranking stage then orders the heads across classes and sends up to `ISSUE_W` of them out, oldest first. A class whose unit reports busy is passed over, and its entries stay where they are.

Entries come in through a single write port. The write names the class, the sequence number and the thread. A squash port removes, in one cycle, every stored entry of one thread that is younger than a given sequence number. Sequence numbers are compared modulo 2^16, so the numbering may wrap, provided the entries in flight cover less than half the number range. Each pool reports when it is full. A write into a full pool is dropped.

Top module: `age_issue_sel`

## Requirements
- R1: While `rst_n` is low at a rising edge, every pool is emptied. After reset, `iss_vld` and `pool_full` are all zero until entries arrive.
- R2: Within one class, entries issue strictly in age order. The smallest sequence number (modulo comparison) leaves first, and at most one entry of a class issues per cycle.
- R3: Across classes, the issued heads are the oldest eligible heads. Slot 0 carries the oldest and each higher slot carries the next-oldest. If two heads have equal sequence numbers, the lower class index counts as older.
- R4: No more than `ISSUE_W` entries issue per cycle. Valid slots are packed from slot 0 upward, and no two valid slots carry the same class.
- R5: If `fu_busy[c]` is 1 in the selection cycle, class c issues nothing in that cycle. Its entries stay stored, and the next-oldest eligible classes take the slots.
- R6: Age is decided by the sign bit of the 16-bit difference of two sequence numbers, so 0xFFF0 is older than 0x0005.
- R7: When `sq_en` is 1, every stored entry whose thread equals `sq_tid` and whose sequence number is younger than `sq_seq` is removed. These entries are also excluded from that cycle's selection. Entries of other threads, and entries equal to or older than `sq_seq`, are kept. A write arriving in the same cycle is not affected.
- R8: An entry written at rising edge N can appear on the issue outputs at the earliest after edge N+1. The outputs are registered. A pool that went empty takes part in selection again as soon as it holds an entry.
- R9: `pool_full[c]` is 1 exactly when class c holds `POOL_DEPTH` entries. A write to a full pool is discarded, even if that pool issues in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write a ready entry this cycle |
| wr_cls | input | CLS_W | Class index (binary) of the written entry |
| wr_seq | input | SEQ_W | Sequence number of the written entry |
| wr_tid | input | TID_W | Thread ID of the written entry |
| fu_busy | input | NUM_CLASSES | Bit c set: class c's unit cannot accept this cycle |
| sq_en | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread to squash |
| sq_seq | input | SEQ_W | Entries of that thread younger than this are removed |
| iss_vld | output | ISSUE_W | Slot k carries an issued entry |
| iss_seq | output | ISSUE_W*SEQ_W | Slot k sequence number at bits [k*SEQ_W +: SEQ_W] |
| iss_cls | output | ISSUE_W*CLS_W | Slot k class at bits [k*CLS_W +: CLS_W] |
| iss_tid | output | ISSUE_W*TID_W | Slot k thread at bits [k*TID_W +: TID_W] |
| pool_full | output | NUM_CLASSES | Bit c set: class c pool has no free slot |

## Verification
The hardest situation to reach is a cycle in which several classes hold competing heads. Normally an entry issues in the cycle after it arrives, so the pools never build up enough for the cross-class ranking to matter. The stimulus holds `fu_busy` high while it loads several classes, then releases the busy bits all at once or class by class. This forces ranking, skipping and packing in the same cycle. The same hold-and-release technique fills a pool to overflow. It also lines up squashes against pools that contain mixed threads and sequence numbers on both sides of the wrap point. A long randomized phase with random busy bits and squashes then checks every cycle against a behavioural model.

// File: rtl/isel_pkg.sv
// Shared helpers for the issue selector.
// Assumes the sequence numbers in flight cover less than half their range.
package isel_pkg;

    // Default geometry used by the top level.
    localparam int DEF_SEQ_W = 16;
    localparam int DEF_TID_W = 2;

    // True when a is older than b, modulo 2^w (w <= 32).
    // Operands are given zero-extended; the low w bits of the 32-bit
    // difference equal the w-bit difference.
    function automatic logic seq_before(input logic [31:0] a,
                                        input logic [31:0] b,
                                        input int          w);
        logic [31:0] diff;
        diff = a - b;
        return diff[w-1];
    endfunction

endpackage

// File: rtl/isel_pool.sv
// One class pool: stores ready entries, finds the oldest live entry,
// takes one write per cycle and drops one issued entry per cycle.
// Assumes pop is only raised while head_vld is set.
module isel_pool
    import isel_pkg::*;
#(
    parameter  int DEPTH = 8,
    parameter  int SEQ_W = 16,
    parameter  int TID_W = 2,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEQ_W-1:0] wr_seq,
    input  logic [TID_W-1:0] wr_tid,
    input  logic             sq_en,
    input  logic [TID_W-1:0] sq_tid,
    input  logic [SEQ_W-1:0] sq_seq,
    input  logic             pop,
    output logic             head_vld,
    output logic [SEQ_W-1:0] head_seq,
    output logic [TID_W-1:0] head_tid,
    output logic             full
);

    logic [DEPTH-1:0] vld_q;
    logic [SEQ_W-1:0] seq_q [DEPTH];
    logic [TID_W-1:0] tid_q [DEPTH];

    logic [DEPTH-1:0] doomed;
    logic [DEPTH-1:0] live;
    logic [IDX_W-1:0] head_idx;
    logic [IDX_W-1:0] free_idx;
    logic             take_wr;
    logic [DEPTH-1:0] vld_nxt;

    // Mark entries hit by this cycle's squash.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            doomed[i] = vld_q[i] && sq_en && (tid_q[i] == sq_tid) &&
                        seq_before(32'(sq_seq), 32'(seq_q[i]), SEQ_W);
        end
        live = vld_q & ~doomed;
    end

    // Find the oldest live entry; ties go to the lower index.
    always_comb begin
        head_vld = 1'b0;
        head_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (live[i] && (!head_vld ||
                seq_before(32'(seq_q[i]), 32'(seq_q[head_idx]), SEQ_W))) begin
                head_vld = 1'b1;
                head_idx = IDX_W'(i);
            end
        end
        head_seq = seq_q[head_idx];
        head_tid = tid_q[head_idx];
    end

    // Pick the lowest free slot for an incoming write.
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_q[i]) free_idx = IDX_W'(i);
        end
        full    = &vld_q;
        take_wr = wr_en && !full;
    end

    // Build next occupancy: drop squashed and issued, add written.
    always_comb begin
        vld_nxt = live;
        if (pop)     vld_nxt[head_idx] = 1'b0;
        if (take_wr) vld_nxt[free_idx] = 1'b1;
    end

    // Occupancy register.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_nxt;
    end

    // Payload storage, written only into a free slot.
    always_ff @(posedge clk) begin
        if (take_wr) begin
            seq_q[free_idx] <= wr_seq;
            tid_q[free_idx] <= wr_tid;
        end
    end

    // R2
    pop_has_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_vld);

    // R9
    full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !sq_en) |=> full);

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_sq_chk
        // R7
        squash_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sq_en && vld_q[gi] && (tid_q[gi] == sq_tid) &&
             seq_before(32'(sq_seq), 32'(seq_q[gi]), SEQ_W)) |=> !vld_q[gi]);
    end

endmodule

// File: rtl/isel_rank.sv
// Cross-class ranking: orders eligible pool heads by age and assigns
// the oldest ISSUE_W of them to output slots, one per class.
// Assumes candidates already exclude busy units and empty pools.
module isel_rank
    import isel_pkg::*;
#(
    parameter  int NC      = 4,
    parameter  int ISSUE_W = 2,
    parameter  int SEQ_W   = 16,
    parameter  int TID_W   = 2,
    localparam int CLS_W   = (NC > 1) ? $clog2(NC) : 1
) (
    input  logic [NC-1:0]                 cand_vld,
    input  logic [NC-1:0][SEQ_W-1:0]      cand_seq,
    input  logic [NC-1:0][TID_W-1:0]      cand_tid,
    output logic [ISSUE_W-1:0]            pick_vld,
    output logic [ISSUE_W-1:0][SEQ_W-1:0] pick_seq,
    output logic [ISSUE_W-1:0][CLS_W-1:0] pick_cls,
    output logic [ISSUE_W-1:0][TID_W-1:0] pick_tid,
    output logic [NC-1:0]                 pop
);

    int unsigned place [NC];

    // Count, per class, how many eligible heads are older.
    always_comb begin
        for (int c = 0; c < NC; c++) begin
            place[c] = 0;
            for (int d = 0; d < NC; d++) begin
                if (d != c && cand_vld[d] &&
                    (seq_before(32'(cand_seq[d]), 32'(cand_seq[c]), SEQ_W) ||
                     (cand_seq[d] == cand_seq[c] && d < c))) begin
                    place[c] = place[c] + 1;
                end
            end
        end
    end

    // Route the class holding place k to slot k.
    always_comb begin
        for (int k = 0; k < ISSUE_W; k++) begin
            pick_vld[k] = 1'b0;
            pick_seq[k] = '0;
            pick_cls[k] = '0;
            pick_tid[k] = '0;
            for (int c = 0; c < NC; c++) begin
                if (cand_vld[c] && place[c] == k) begin
                    pick_vld[k] = 1'b1;
                    pick_seq[k] = cand_seq[c];
                    pick_cls[k] = CLS_W'(c);
                    pick_tid[k] = cand_tid[c];
                end
            end
        end
    end

    // Tell each winning pool to drop its head.
    always_comb begin
        for (int c = 0; c < NC; c++) begin
            pop[c] = cand_vld[c] && (place[c] < ISSUE_W);
        end
    end

endmodule

// File: rtl/age_issue_sel.sv
// Age-ordered issue selector: per-class ready pools with head tracking,
// cross-class oldest-first ranking, busy-unit skipping and thread squash.
// Assumes sequence numbers in flight span less than half their range.
module age_issue_sel
    import isel_pkg::*;
#(
    parameter  int NUM_CLASSES = 4,
    parameter  int POOL_DEPTH  = 8,
    parameter  int ISSUE_W     = 2,
    parameter  int SEQ_W       = DEF_SEQ_W,
    parameter  int TID_W       = DEF_TID_W,
    localparam int CLS_W       = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [CLS_W-1:0]         wr_cls,
    input  logic [SEQ_W-1:0]         wr_seq,
    input  logic [TID_W-1:0]         wr_tid,
    input  logic [NUM_CLASSES-1:0]   fu_busy,
    input  logic                     sq_en,
    input  logic [TID_W-1:0]         sq_tid,
    input  logic [SEQ_W-1:0]         sq_seq,
    output logic [ISSUE_W-1:0]       iss_vld,
    output logic [ISSUE_W*SEQ_W-1:0] iss_seq,
    output logic [ISSUE_W*CLS_W-1:0] iss_cls,
    output logic [ISSUE_W*TID_W-1:0] iss_tid,
    output logic [NUM_CLASSES-1:0]   pool_full
);

    logic [NUM_CLASSES-1:0]            head_vld;
    logic [NUM_CLASSES-1:0][SEQ_W-1:0] head_seq;
    logic [NUM_CLASSES-1:0][TID_W-1:0] head_tid;
    logic [NUM_CLASSES-1:0]            pop;
    logic [NUM_CLASSES-1:0]            cand_vld;

    logic [ISSUE_W-1:0]                pick_vld;
    logic [ISSUE_W-1:0][SEQ_W-1:0]     pick_seq;
    logic [ISSUE_W-1:0][CLS_W-1:0]     pick_cls;
    logic [ISSUE_W-1:0][TID_W-1:0]     pick_tid;

    for (genvar gc = 0; gc < NUM_CLASSES; gc++) begin : g_pool
        isel_pool #(
            .DEPTH (POOL_DEPTH),
            .SEQ_W (SEQ_W),
            .TID_W (TID_W)
        ) u_pool (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en && (wr_cls == CLS_W'(gc))),
            .wr_seq   (wr_seq),
            .wr_tid   (wr_tid),
            .sq_en    (sq_en),
            .sq_tid   (sq_tid),
            .sq_seq   (sq_seq),
            .pop      (pop[gc]),
            .head_vld (head_vld[gc]),
            .head_seq (head_seq[gc]),
            .head_tid (head_tid[gc]),
            .full     (pool_full[gc])
        );
    end

    // A head competes only while its unit can accept.
    always_comb cand_vld = head_vld & ~fu_busy;

    isel_rank #(
        .NC      (NUM_CLASSES),
        .ISSUE_W (ISSUE_W),
        .SEQ_W   (SEQ_W),
        .TID_W   (TID_W)
    ) u_rank (
        .cand_vld (cand_vld),
        .cand_seq (head_seq),
        .cand_tid (head_tid),
        .pick_vld (pick_vld),
        .pick_seq (pick_seq),
        .pick_cls (pick_cls),
        .pick_tid (pick_tid),
        .pop      (pop)
    );

    // Register the issue slots toward the functional units.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_vld <= '0;
            iss_seq <= '0;
            iss_cls <= '0;
            iss_tid <= '0;
        end else begin
            iss_vld <= pick_vld;
            iss_seq <= pick_seq;
            iss_cls <= pick_cls;
            iss_tid <= pick_tid;
        end
    end

    for (genvar gk = 0; gk < ISSUE_W; gk++) begin : g_slot_chk
        // R5
        busy_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
            iss_vld[gk] |->
            (((NUM_CLASSES'(1) << iss_cls[gk*CLS_W +: CLS_W]) & $past(fu_busy)) == '0));
        if (gk > 0) begin : g_pair
            // R4
            packed_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
                iss_vld[gk] |-> (iss_vld[gk-1] &&
                iss_cls[gk*CLS_W +: CLS_W] != iss_cls[(gk-1)*CLS_W +: CLS_W]));
            // R3
            slot_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
                iss_vld[gk] |-> !seq_before(32'(iss_seq[gk*SEQ_W +: SEQ_W]),
                                            32'(iss_seq[(gk-1)*SEQ_W +: SEQ_W]), SEQ_W));
        end
    end

endmodule

// File: tb/sim_age_issue_sel.sv
module sim_age_issue_sel;

    localparam int NC = 4;
    localparam int D  = 8;
    localparam int IW = 2;

    typedef struct packed {
        logic [15:0] s;
        logic [1:0]  t;
    } ment_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_cls = '0;
    logic [15:0] wr_seq = '0;
    logic [1:0]  wr_tid = '0;
    logic [3:0]  fu_busy = '0;
    logic        sq_en = 1'b0;
    logic [1:0]  sq_tid = '0;
    logic [15:0] sq_seq = '0;
    logic [1:0]  iss_vld;
    logic [31:0] iss_seq;
    logic [3:0]  iss_cls;
    logic [3:0]  iss_tid;
    logic [3:0]  pool_full;

    age_issue_sel u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cls(wr_cls),
        .wr_seq(wr_seq), .wr_tid(wr_tid), .fu_busy(fu_busy),
        .sq_en(sq_en), .sq_tid(sq_tid), .sq_seq(sq_seq),
        .iss_vld(iss_vld), .iss_seq(iss_seq), .iss_cls(iss_cls),
        .iss_tid(iss_tid), .pool_full(pool_full)
    );

    always #10 clk = ~clk;

    ment_t       mq [NC][$];
    logic [1:0]  e_vld;
    logic [15:0] e_seq [IW];
    logic [1:0]  e_cls [IW];
    logic [1:0]  e_tid [IW];
    logic [3:0]  e_full;
    int          n_chk = 0;
    int          n_bad = 0;
    string       cur_req = "R1";
    bit          done = 0;

    function automatic bit older(input logic [15:0] a, input logic [15:0] b);
        logic [15:0] d;
        d = a - b;
        return d[15];
    endfunction

    // Compare the registered outputs with the model's expectation.
    task automatic compare();
        bit bad;
        n_chk++;
        bad = (iss_vld != e_vld);
        for (int k = 0; k < IW; k++) begin
            if (e_vld[k] && (iss_seq[k*16 +: 16] != e_seq[k] ||
                iss_cls[k*2 +: 2] != e_cls[k] || iss_tid[k*2 +: 2] != e_tid[k]))
                bad = 1;
        end
        if (bad) begin
            n_bad++;
            $display("FAIL %s issue: vld=%b seq=%h/%h cls=%h tid=%h expected vld=%b seq=%h/%h cls=%0d/%0d tid=%0d/%0d",
                     cur_req, iss_vld, iss_seq[31:16], iss_seq[15:0], iss_cls, iss_tid,
                     e_vld, e_seq[1], e_seq[0], e_cls[1], e_cls[0], e_tid[1], e_tid[0]);
        end
        n_chk++;
        if (pool_full != e_full) begin
            n_bad++;
            $display("FAIL R9 (%s) pool_full=%b expected %b", cur_req, pool_full, e_full);
        end
    endtask

    // Advance the reference model by one clock using the driven inputs.
    task automatic model();
        int    pre [NC];
        int    hidx [NC];
        bit    used [NC];
        ment_t w;
        for (int c = 0; c < NC; c++) pre[c] = mq[c].size();
        if (sq_en) begin
            for (int c = 0; c < NC; c++)
                for (int i = mq[c].size() - 1; i >= 0; i--)
                    if (mq[c][i].t == sq_tid && older(sq_seq, mq[c][i].s))
                        mq[c].delete(i);
        end
        for (int c = 0; c < NC; c++) begin
            hidx[c] = -1;
            used[c] = 0;
            for (int i = 0; i < mq[c].size(); i++)
                if (hidx[c] < 0 || older(mq[c][i].s, mq[c][hidx[c]].s)) hidx[c] = i;
        end
        for (int k = 0; k < IW; k++) begin
            int best;
            best = -1;
            for (int c = 0; c < NC; c++) begin
                if (!fu_busy[c] && !used[c] && hidx[c] >= 0) begin
                    if (best < 0 || older(mq[c][hidx[c]].s, mq[best][hidx[best]].s))
                        best = c;
                end
            end
            e_vld[k] = (best >= 0);
            if (best >= 0) begin
                e_seq[k] = mq[best][hidx[best]].s;
                e_tid[k] = mq[best][hidx[best]].t;
                e_cls[k] = 2'(best);
                used[best] = 1;
            end
        end
        for (int c = 0; c < NC; c++)
            if (used[c]) mq[c].delete(hidx[c]);
        if (wr_en && pre[wr_cls] < D) begin
            w.s = wr_seq;
            w.t = wr_tid;
            mq[wr_cls].push_back(w);
        end
        for (int c = 0; c < NC; c++) e_full[c] = (mq[c].size() == D);
    endtask

    // One cycle: check outputs, drive inputs, step the model.
    task automatic cyc(input bit we, input int cls, input logic [15:0] s,
                       input int t, input logic [3:0] busy,
                       input bit sqe, input int sqt, input logic [15:0] sqs);
        @(negedge clk);
        compare();
        wr_en   = we;
        wr_cls  = 2'(cls);
        wr_seq  = s;
        wr_tid  = 2'(t);
        fu_busy = busy;
        sq_en   = sqe;
        sq_tid  = 2'(sqt);
        sq_seq  = sqs;
        model();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 4'h0, 0, 0, 0);
    endtask

    initial begin
        e_vld  = '0;
        e_full = '0;
        for (int k = 0; k < IW; k++) begin
            e_seq[k] = '0;
            e_cls[k] = '0;
            e_tid[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs clear after reset
        cur_req = "R1";
        idle(2);
        // R2: same-class entries leave oldest first
        cur_req = "R2";
        cyc(1, 0, 16'd30, 0, 4'hF, 0, 0, 0);
        cyc(1, 0, 16'd10, 0, 4'hF, 0, 0, 0);
        cyc(1, 0, 16'd20, 0, 4'hF, 0, 0, 0);
        idle(5);
        // R3: cross-class oldest heads, slot 0 oldest
        cur_req = "R3";
        cyc(1, 1, 16'd50, 1, 4'hF, 0, 0, 0);
        cyc(1, 2, 16'd40, 2, 4'hF, 0, 0, 0);
        cyc(1, 3, 16'd45, 3, 4'hF, 0, 0, 0);
        cyc(1, 0, 16'd60, 0, 4'hF, 0, 0, 0);
        idle(4);
        // R4: four classes loaded, only two issue per cycle
        cur_req = "R4";
        for (int c = 0; c < NC; c++) cyc(1, c, 16'(70 + c), c, 4'hF, 0, 0, 0);
        idle(4);
        // R5: busy class holding the oldest entry is skipped
        cur_req = "R5";
        cyc(1, 2, 16'd80, 0, 4'hF, 0, 0, 0);
        cyc(1, 1, 16'd81, 0, 4'hF, 0, 0, 0);
        cyc(1, 0, 16'd82, 0, 4'hF, 0, 0, 0);
        cyc(0, 0, 0, 0, 4'h4, 0, 0, 0);
        cyc(0, 0, 0, 0, 4'h4, 0, 0, 0);
        idle(3);
        // R6: wrapped sequence numbers
        cur_req = "R6";
        cyc(1, 0, 16'h0005, 1, 4'hF, 0, 0, 0);
        cyc(1, 1, 16'hFFF0, 1, 4'hF, 0, 0, 0);
        cyc(1, 2, 16'hFFFE, 1, 4'hF, 0, 0, 0);
        idle(4);
        // R7: squash younger entries of one thread only
        cur_req = "R7";
        cyc(1, 0, 16'd100, 1, 4'hF, 0, 0, 0);
        cyc(1, 0, 16'd101, 1, 4'hF, 0, 0, 0);
        cyc(1, 1, 16'd102, 1, 4'hF, 0, 0, 0);
        cyc(1, 0, 16'd103, 0, 4'hF, 0, 0, 0);
        cyc(0, 0, 0, 0, 4'h0, 1, 1, 16'd100);
        idle(4);
        // R8: empty pool re-enters selection, two-edge latency
        cur_req = "R8";
        cyc(1, 3, 16'd110, 2, 4'h0, 0, 0, 0);
        idle(2);
        cyc(1, 3, 16'd111, 2, 4'h0, 0, 0, 0);
        idle(3);
        // R9: overfill class 3, ninth write dropped
        cur_req = "R9";
        for (int i = 0; i < D + 1; i++) cyc(1, 3, 16'(120 + i), 0, 4'hF, 0, 0, 0);
        cyc(1, 3, 16'd119, 0, 4'h0, 0, 0, 0);
        idle(12);
        // R4: randomized traffic across the wrap point
        cur_req = "R4";
        begin
            logic [15:0] ctr;
            ctr = 16'hFF80;
            for (int n = 0; n < 3000; n++) begin
                bit  we;
                bit  sqe;
                logic [3:0] busy;
                we   = ($urandom_range(0, 3) != 0);
                sqe  = ($urandom_range(0, 19) == 0);
                busy = ($urandom_range(0, 1) != 0) ? 4'($urandom_range(0, 15)) : 4'h0;
                if (we) ctr = ctr + 16'd1;
                cyc(we, $urandom_range(0, 3), ctr, $urandom_range(0, 3), busy,
                    sqe, $urandom_range(0, 3), ctr - 16'($urandom_range(0, 10)));
            end
        end
        idle(12);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R8 watchdog: run still going, expected finish before 200000 cycles");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule